// File: doc/BRIEF.md
# Integer/FP Dual-Issue Occupancy Tracker

This block sits at the issue stage of a core that may launch one integer instruction and one floating-point instruction in the same clock. Each cycle it looks at the instruction waiting in the integer slot and the one waiting in the FP slot. It decides which of the two may go, and it raises a stall when a waiting instruction is held.

It keeps its own scoreboard. Each of the 32 FP registers, and the single FP condition flag, has a countdown to the cycle in which its result may be consumed. A second countdown covers the part of the FPU that is not pipelined, so that long divides and square roots block later FP work for their full occupancy. How long a result takes to appear and how long the FPU is held are tracked separately for each operation.

An FP instruction that cannot go is held in its slot until it can. An integer instruction that does not read the FP condition is never held back by the FP side. The one exception is a transfer between the integer and FP register files, which needs both pipes.

Top module: `fp_dual_issue`

## Requirements
- R1: An integer instruction and an FP instruction that are both ready are granted in the same cycle. Only one instruction per slot is granted per cycle.
- R2: A dependent FP instruction issues exactly L cycles after its producer, where L is the producer's result latency. The FP operation codes on `fp_op` are: 0 add/abs/neg (L=4, reads A and B), 1 move (L=4, reads A), 3 load (L=3, no FP source), 4 store (L=1, reads A, writes nothing). Every code that writes a register writes `fp_dst`.
- R3: Code 5 is multiply or multiply-add and reads A and B. With `fp_dbl`=0 it has L=4 and holds the FPU for 1 cycle. With `fp_dbl`=1 it has L=5 and holds the FPU for 2 cycles.
- R4: Code 6 is divide or square root and reads A and B. With `fp_dbl`=0 it has L=17 and holds the FPU for 14 cycles; with `fp_dbl`=1 it has L=32 and holds it for 29. Code 7 is reciprocal square root and reads A; with `fp_dbl`=0 it has L=17 and holds 14 cycles, with `fp_dbl`=1 it has L=35 and holds 31. While the FPU is held, no FP instruction is granted.
- R5: Code 8 is compare. It reads A and B and writes only the condition flag. An integer instruction with `int_fcc`=1 reads the flag and issues no earlier than 2 cycles after the compare. A conditional move, code 2 (L=4, reads A and the flag), may issue 1 cycle after the compare.
- R6: The conversions each read A and write `fp_dst`. Code 9 covers integer to single, integer to double and single to double, with L=4. Code 10 is FP to integer, with L=5. Code 11 is double to single, with L=6.
- R7: Code 12 moves a value from the integer file into `fp_dst`, with L=2 and no FP source. Code 13 moves A to the integer file. A transfer is never granted together with an integer instruction. When both slots are ready, the integer slot goes first and the transfer goes in a later cycle.
- R8: When the FP slot is held, an integer instruction with `int_fcc`=0 is still granted in the same cycle, and the FP instruction stays held until its operands and the FPU are free.
- R9: When two writes to the same register are pending, that register becomes ready at the later of the two completion times.
- R10: Reset clears every countdown. An FP instruction presented right after reset is granted at once, whatever its source registers.
- R11: Apart from the occupancy countdown, all other FP operations hold the FPU for 1 cycle and are pipelined back to back.
- R12: `stall` is high exactly when a valid slot is not granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_valid | input | 1 | Integer slot holds an instruction |
| int_fcc | input | 1 | Integer instruction reads the FP condition flag |
| fp_valid | input | 1 | FP slot holds an instruction |
| fp_op | input | 4 | FP operation code (see R2 to R7) |
| fp_dbl | input | 1 | Double precision form |
| fp_dst | input | 5 | FP destination register |
| fp_srca | input | 5 | First FP source register |
| fp_srcb | input | 5 | Second FP source register |
| int_grant | output | 1 | Integer slot issues this cycle |
| fp_grant | output | 1 | FP slot issues this cycle |
| stall | output | 1 | Some valid slot is held this cycle |

## Verification
The bench targets the cycles where latency and occupancy part ways. A DP multiply must block the next FP operation for one extra cycle, and a DP reciprocal square root must hold the FPU for 31 cycles while its result lands at 35; a design that merged the two counts would release readers or the FPU too early or too late. The compare path is driven both into a conditional move and into an integer branch on the flag, so a design that applied the shortened path to the branch, or missed it for the move, shows up as a one-cycle skew. Transfers are presented alongside integer work to catch illegal co-issue, and a short-latency write that lands behind a long one catches a scoreboard that simply overwrites. A long random stream compared against a time-stamped model covers the mixes between these cases.

// File: rtl/fp_dual_issue.sv
module fp_dual_issue #(
  parameter int NREG = 32,
  parameter int CW   = 6,
  parameter int BW   = 5,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_valid,
  input  logic          int_fcc,
  input  logic          fp_valid,
  input  logic [3:0]    fp_op,
  input  logic          fp_dbl,
  input  logic [RW-1:0] fp_dst,
  input  logic [RW-1:0] fp_srca,
  input  logic [RW-1:0] fp_srcb,
  output logic          int_grant,
  output logic          fp_grant,
  output logic          stall
);

  logic [CW-1:0] cnt   [NREG];
  logic [CW-1:0] cnt_n [NREG];
  logic [1:0]    fcnt, fcnt_n;
  logic [BW-1:0] busy;

  logic [CW-1:0] lat;
  logic [BW-1:0] occ;
  logic rd_a, rd_b, rd_f, wr_d, wr_f, xfer;

  always_comb begin
    lat = CW'(1); occ = BW'(1);
    rd_a = 1'b0; rd_b = 1'b0; rd_f = 1'b0;
    wr_d = 1'b0; wr_f = 1'b0; xfer = 1'b0;
    case (fp_op)
      4'd0:  begin lat = CW'(4); rd_a = 1'b1; rd_b = 1'b1; wr_d = 1'b1; end
      4'd1:  begin lat = CW'(4); rd_a = 1'b1; wr_d = 1'b1; end
      4'd2:  begin lat = CW'(4); rd_a = 1'b1; rd_f = 1'b1; wr_d = 1'b1; end
      4'd3:  begin lat = CW'(3); wr_d = 1'b1; end
      4'd4:  begin lat = CW'(1); rd_a = 1'b1; end
      4'd5:  begin
               lat = fp_dbl ? CW'(5) : CW'(4);
               occ = fp_dbl ? BW'(2) : BW'(1);
               rd_a = 1'b1; rd_b = 1'b1; wr_d = 1'b1;
             end
      4'd6:  begin
               lat = fp_dbl ? CW'(32) : CW'(17);
               occ = fp_dbl ? BW'(29) : BW'(14);
               rd_a = 1'b1; rd_b = 1'b1; wr_d = 1'b1;
             end
      4'd7:  begin
               lat = fp_dbl ? CW'(35) : CW'(17);
               occ = fp_dbl ? BW'(31) : BW'(14);
               rd_a = 1'b1; wr_d = 1'b1;
             end
      4'd8:  begin lat = CW'(2); rd_a = 1'b1; rd_b = 1'b1; wr_f = 1'b1; end
      4'd9:  begin lat = CW'(4); rd_a = 1'b1; wr_d = 1'b1; end
      4'd10: begin lat = CW'(5); rd_a = 1'b1; wr_d = 1'b1; end
      4'd11: begin lat = CW'(6); rd_a = 1'b1; wr_d = 1'b1; end
      4'd12: begin lat = CW'(2); wr_d = 1'b1; xfer = 1'b1; end
      4'd13: begin lat = CW'(2); rd_a = 1'b1; xfer = 1'b1; end
      default: ;
    endcase
  end

  logic a_ok, b_ok, f_ok, fp_ok, int_go;
  assign a_ok   = !rd_a || cnt[fp_srca] == '0;
  assign b_ok   = !rd_b || cnt[fp_srcb] == '0;
  assign f_ok   = !rd_f || fcnt <= 2'd1;
  assign fp_ok  = fp_valid && busy == '0 && a_ok && b_ok && f_ok;
  assign int_go = int_valid && (!int_fcc || fcnt == '0);

  assign int_grant = int_go;
  assign fp_grant  = fp_ok && !(xfer && int_go);
  assign stall     = (int_valid && !int_grant) || (fp_valid && !fp_grant);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cnt_n[i] = (cnt[i] == '0) ? '0 : cnt[i] - 1'b1;
      if (fp_grant && wr_d && fp_dst == RW'(i) && (lat - 1'b1) > cnt_n[i])
        cnt_n[i] = lat - 1'b1;
    end
    fcnt_n = (fcnt == '0) ? '0 : fcnt - 1'b1;
    if (fp_grant && wr_f) fcnt_n = 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cnt[i] <= '0;
      fcnt <= '0;
      busy <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) cnt[i] <= cnt_n[i];
      fcnt <= fcnt_n;
      if (fp_grant)          busy <= occ - 1'b1;
      else if (busy != '0)   busy <= busy - 1'b1;
    end
  end

  // R7
  xfer_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_grant && xfer |-> !int_grant);

  // R4
  occ_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_grant && occ > BW'(1) |=> !fp_grant);

  // R8
  int_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid && !int_fcc |-> int_grant);

  // R2
  raw_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_grant && wr_d && lat > CW'(1) |=> !(fp_grant && rd_a && fp_srca == $past(fp_dst)));

  // R5
  flag_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_grant && wr_f |=> !(int_grant && int_fcc));

endmodule

// File: tb/test_fp_dual_issue.sv
`timescale 1ns/1ps
module test_fp_dual_issue;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_valid = 1'b0, int_fcc = 1'b0, fp_valid = 1'b0, fp_dbl = 1'b0;
  logic [3:0] fp_op = '0;
  logic [4:0] fp_dst = '0, fp_srca = '0, fp_srcb = '0;
  logic int_grant, fp_grant, stall;

  always #2 clk = ~clk;

  fp_dual_issue i_fp_dual_issue (
    .clk(clk), .rst_n(rst_n), .int_valid(int_valid), .int_fcc(int_fcc),
    .fp_valid(fp_valid), .fp_op(fp_op), .fp_dbl(fp_dbl), .fp_dst(fp_dst),
    .fp_srca(fp_srca), .fp_srcb(fp_srcb),
    .int_grant(int_grant), .fp_grant(fp_grant), .stall(stall));

  int checks = 0, errs = 0;
  bit done = 0;
  int n = 0;
  int rdy [32];
  int fpu_free = 0;
  int flag_rdy = 0;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, n);
    end
  endtask

  function automatic void decode(input bit [3:0] op, input bit dbl,
      output int lat, output int occ,
      output bit ra, output bit rb, output bit rf,
      output bit wd, output bit wf, output bit x);
    lat = 1; occ = 1; ra = 0; rb = 0; rf = 0; wd = 0; wf = 0; x = 0;
    case (op)
      0:  begin lat = 4; ra = 1; rb = 1; wd = 1; end
      1:  begin lat = 4; ra = 1; wd = 1; end
      2:  begin lat = 4; ra = 1; rf = 1; wd = 1; end
      3:  begin lat = 3; wd = 1; end
      4:  begin lat = 1; ra = 1; end
      5:  begin lat = dbl ? 5 : 4;   occ = dbl ? 2 : 1;   ra = 1; rb = 1; wd = 1; end
      6:  begin lat = dbl ? 32 : 17; occ = dbl ? 29 : 14; ra = 1; rb = 1; wd = 1; end
      7:  begin lat = dbl ? 35 : 17; occ = dbl ? 31 : 14; ra = 1; wd = 1; end
      8:  begin lat = 2; ra = 1; rb = 1; wf = 1; end
      9:  begin lat = 4; ra = 1; wd = 1; end
      10: begin lat = 5; ra = 1; wd = 1; end
      11: begin lat = 6; ra = 1; wd = 1; end
      12: begin lat = 2; wd = 1; x = 1; end
      13: begin lat = 2; ra = 1; x = 1; end
      default: ;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) rdy[i] = 0;
    fpu_free = 0;
    flag_rdy = 0;
  endtask

  task automatic step(input string tag, input bit iv, input bit ifc, input bit fv,
      input bit [3:0] op, input bit dbl, input bit [4:0] d, input bit [4:0] a,
      input bit [4:0] b, output bit gi, output bit gf);
    int lat, occ;
    bit ra, rb, rf, wd, wf, x, ok, es;
    @(negedge clk);
    int_valid = iv; int_fcc = ifc; fp_valid = fv; fp_op = op; fp_dbl = dbl;
    fp_dst = d; fp_srca = a; fp_srcb = b;
    #1;
    decode(op, dbl, lat, occ, ra, rb, rf, wd, wf, x);
    gi = iv && (!ifc || n >= flag_rdy);
    ok = fv && n >= fpu_free && (!ra || n >= rdy[a]) && (!rb || n >= rdy[b])
         && (!rf || n >= flag_rdy - 1);
    gf = ok && !(x && gi);
    es = (iv && !gi) || (fv && !gf);
    check({tag, " int_grant"}, int'(int_grant), int'(gi));
    check({tag, " fp_grant"}, int'(fp_grant), int'(gf));
    check("R12 stall", int'(stall), int'(es));
    if (gf) begin
      fpu_free = n + occ;
      if (wd && n + lat > rdy[d]) rdy[d] = n + lat;
      if (wf && n + 2 > flag_rdy) flag_rdy = n + 2;
    end
    n++;
  endtask

  task automatic idle(input int k);
    bit gi, gf;
    for (int i = 0; i < k; i++) step("R10", 0, 0, 0, 0, 0, 0, 0, 0, gi, gf);
  endtask

  task automatic issue(input string tag, input bit iv, input bit ifc, input bit fv,
      input bit [3:0] op, input bit dbl, input bit [4:0] d, input bit [4:0] a,
      input bit [4:0] b, output int ti, output int tf);
    bit pi, pf, gi, gf;
    pi = iv; pf = fv; ti = -1; tf = -1;
    for (int k = 0; k < 80 && (pi || pf); k++) begin
      step(tag, pi, ifc, pf, op, dbl, d, a, b, gi, gf);
      if (gi) begin ti = n - 1; pi = 0; end
      if (gf) begin tf = n - 1; pf = 0; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    int_valid = 0; fp_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int ti, tf, t0, x1, x2;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: idle outputs after reset, then a reader of any register goes at once
    idle(2);
    issue("R10", 0, 0, 1, 0, 0, 2, 31, 30, ti, tf);
    check("R10 first FP issue", tf, n - 1);
    idle(8);

    // R1 co-issue, R2 add latency
    issue("R1", 1, 0, 1, 0, 0, 1, 2, 3, ti, tf);
    check("R1 same cycle", ti, tf);
    t0 = tf;
    issue("R2", 0, 0, 1, 0, 0, 4, 1, 1, ti, tf);
    check("R2 add latency", tf - t0, 4);
    idle(8);

    // R8: independent integer not held by a blocked FP slot
    issue("R8", 0, 0, 1, 1, 0, 6, 2, 2, ti, t0);
    issue("R8", 1, 0, 1, 0, 0, 7, 6, 6, ti, tf);
    check("R8 int goes alone", ti - t0, 1);
    check("R8 FP held to ready", tf - t0, 4);
    idle(8);

    // R2 load then store
    issue("R2", 0, 0, 1, 3, 0, 8, 0, 0, ti, t0);
    issue("R2", 0, 0, 1, 4, 0, 0, 8, 8, ti, tf);
    check("R2 load latency", tf - t0, 3);
    idle(8);

    // R3 multiply
    issue("R3", 0, 0, 1, 5, 1, 10, 0, 0, ti, t0);
    issue("R3", 0, 0, 1, 0, 0, 11, 0, 0, ti, tf);
    check("R3 DP mul occupancy", tf - t0, 2);
    idle(10);
    issue("R3", 0, 0, 1, 5, 1, 12, 0, 0, ti, t0);
    issue("R3", 0, 0, 1, 1, 0, 13, 12, 12, ti, tf);
    check("R3 DP mul latency", tf - t0, 5);
    idle(10);
    issue("R3", 0, 0, 1, 5, 0, 14, 0, 0, ti, t0);
    issue("R11", 0, 0, 1, 0, 0, 15, 0, 0, ti, tf);
    check("R11 SP mul pipelined", tf - t0, 1);
    issue("R3", 0, 0, 1, 1, 0, 16, 14, 14, ti, tf);
    check("R3 SP mul latency", tf - t0, 4);
    idle(10);

    // R4 divide / square root / reciprocal square root
    for (int v = 0; v < 4; v++) begin
      bit [3:0] op = (v < 2) ? 4'd6 : 4'd7;
      bit dbl = v[0];
      int eo = (v == 0 || v == 2) ? 14 : (v == 1 ? 29 : 31);
      int el = (v == 0 || v == 2) ? 17 : (v == 1 ? 32 : 35);
      issue("R4", 0, 0, 1, op, dbl, 17, 0, 0, ti, t0);
      issue("R4", 0, 0, 1, 0, 0, 18, 0, 0, ti, tf);
      check("R4 occupancy", tf - t0, eo);
      issue("R4", 0, 0, 1, 1, 0, 19, 17, 17, ti, tf);
      check("R4 latency", tf - t0, el);
      idle(10);
    end

    // R5 compare into conditional move and into integer branch
    issue("R5", 0, 0, 1, 8, 0, 0, 1, 2, ti, t0);
    issue("R5", 0, 0, 1, 2, 0, 20, 3, 3, ti, tf);
    check("R5 cmove bypass", tf - t0, 1);
    idle(8);
    issue("R5", 0, 0, 1, 8, 0, 0, 1, 2, ti, t0);
    issue("R5", 1, 1, 0, 0, 0, 0, 0, 0, ti, tf);
    check("R5 branch on flag", ti - t0, 2);
    idle(8);

    // R6 conversions
    for (int v = 0; v < 3; v++) begin
      issue("R6", 0, 0, 1, 4'(9 + v), 0, 21, 0, 0, ti, t0);
      issue("R6", 0, 0, 1, 1, 0, 22, 21, 21, ti, tf);
      check("R6 conversion latency", tf - t0, 4 + v);
      idle(8);
    end

    // R7 transfers
    issue("R7", 1, 0, 1, 12, 0, 23, 0, 0, ti, tf);
    check("R7 int first", tf - ti, 1);
    t0 = tf;
    issue("R7", 0, 0, 1, 1, 0, 24, 23, 23, ti, tf);
    check("R7 transfer latency", tf - t0, 2);
    idle(4);
    issue("R7", 1, 0, 1, 13, 0, 0, 24, 0, ti, tf);
    check("R7 from-FP not co-issued", tf - ti, 1);
    idle(8);

    // R9 two pending writes, later one wins
    issue("R9", 0, 0, 1, 11, 0, 25, 0, 0, ti, t0);
    issue("R9", 0, 0, 1, 3, 0, 25, 0, 0, ti, tf);
    check("R9 second write next cycle", tf - t0, 1);
    issue("R9", 0, 0, 1, 1, 0, 26, 25, 25, ti, tf);
    check("R9 reader waits for later", tf - t0, 6);
    idle(8);

    // R10 reset in the middle of a long operation
    issue("R10", 0, 0, 1, 7, 1, 27, 0, 0, ti, t0);
    do_reset();
    issue("R10", 0, 0, 1, 0, 0, 28, 27, 27, ti, tf);
    check("R10 cleared after reset", tf, n - 1);
    idle(8);

    // random mix against the model
    begin
      bit ci, cfc, cf, cdb, gi, gf;
      bit [3:0] cop;
      bit [4:0] cd, ca, cb;
      ci = 0; cfc = 0; cf = 0; cop = 0; cdb = 0; cd = 0; ca = 0; cb = 0;
      for (int k = 0; k < 4000; k++) begin
        step("R2", ci, cfc, cf, cop, cdb, cd, ca, cb, gi, gf);
        if (gi || !ci) begin
          ci = ($urandom % 3) != 0;
          cfc = ($urandom % 4) == 0;
        end
        if (gf || !cf) begin
          cf = ($urandom % 4) != 0;
          cop = 4'($urandom % 14);
          cdb = 1'($urandom % 2);
          cd = 5'($urandom % 8);
          ca = 5'($urandom % 8);
          cb = 5'($urandom % 8);
        end
      end
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule